// File: doc/BRIEF.md
# Flash Operation Sequencer with Busy Handshake

This block executes already-decoded flash commands (byte program, sector erase, main-partition erase, whole-array erase and byte verify) against a byte-addressed storage array held in registers. Each modifying command runs for a fixed number of clock cycles. The cycle counts are parameters, and their defaults are derived from the clock rate so that they match real flash timing. During the run the `ready` output is low. When the run ends the array content changes, `ready` returns high and `done` pulses for one cycle.

Lock status comes from a separate security bank. A sector erase, a byte program or a verify is refused or masked while a lock is active. The two bulk erases override the lock. A verify issued while a program is still running does not read the array. Instead it returns a polling pattern built from the byte being programmed, so a host can poll for completion through the data path as well as through `ready`.

Storage indices are the low address bits. The main partition is the first `P0_BYTES` bytes, and sectors are aligned blocks of `SECTOR_BYTES` (128) bytes. When several command strobes arrive in the same cycle, the one accepted is, in falling priority: whole-array erase, partition erase, sector erase, program.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `rdata` is 00H, and every byte of the array reads FFH.
- R2: A program combines the new byte with the stored byte by bitwise AND. A bit can fall from 1 to 0 but never rise without an erase.
- R3: `ready` falls in the cycle after an accepted strobe and stays low for exactly PROG_CYC, SECT_CYC, PART_CYC or CHIP_CYC cycles, depending on the operation. In the cycle where `ready` rises, `done` is 1, and it is 0 in the following cycle.
- R4: A sector erase sets to FFH every byte whose index shares all bits above bit 6 with the given address, and no other byte. It is refused while `lock_active` is 1.
- R5: A partition erase sets to FFH every byte with index below P0_BYTES and leaves the other bytes alone. It proceeds even when `lock_active` is 1.
- R6: A whole-array erase sets every byte to FFH, even when `lock_active` is 1.
- R7: A program issued while `lock_active` is 1 is refused. `ready` stays high, `done` stays low and the array is unchanged.
- R8: When idle, `cmd_verify` loads `rdata` one cycle later with the addressed byte. If `lock_active` is 1, it loads 00H instead.
- R9: A verify issued while a program runs returns the inverse of bit 3 of the data being programmed on bit 3, with all other bits 0, whatever the address. A verify issued during an erase returns 00H.
- R10: Command strobes that arrive while `ready` is low are dropped. They change neither the running operation, nor its length, nor the array.
- R11: An address with any bit set at or above log2(MEM_BYTES) lies outside the array. A program or sector erase aimed there is refused, and a verify there returns 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_prog | input | 1 | One-cycle strobe: program byte |
| cmd_sect_erase | input | 1 | One-cycle strobe: erase addressed sector |
| cmd_part_erase | input | 1 | One-cycle strobe: erase main partition |
| cmd_chip_erase | input | 1 | One-cycle strobe: erase whole array |
| cmd_verify | input | 1 | One-cycle strobe: read addressed byte into rdata |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Data for program |
| lock_active | input | 1 | A security lock is set |
| rdata | output | 8 | Verify result, held until the next verify |
| ready | output | 1 | 1 = idle, 0 = operation running |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
Programs are applied twice to one byte with overlapping bit patterns. This separates an AND merge from a plain overwrite. Programs and sector erases are placed at the first and last byte of a sector and at the bytes just outside it, which exposes an off-by-one in the sector compare. Each erase kind is run with the lock set and with it clear, so a wrong override rule shows up as a changed or unchanged byte. Verifies issued mid-operation, together with strobes injected mid-operation, tell the polling pattern apart from array data, and show whether a busy run is stretched or restarted.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash operation sequencer.
package flash_seq_pkg;
    // Operation being timed; the order of the values carries no meaning.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_PART = 3'd3,
        OP_CHIP = 3'd4
    } flash_op_e;
endpackage

// File: rtl/flash_op_timer.sv
// Down-counter that times one flash operation.
// Assumes: load is raised only while idle, and load_val >= 1.
// expire is high in the last cycle of the timed window.
module flash_op_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic             running;
    logic [CNT_W-1:0] cnt;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= load_val - 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    // Flag the final cycle of the window.
    assign expire = running && (cnt == '0);

    // The controller must never start a new window over a running one.
    p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running);
endmodule

// File: rtl/flash_byte_array.sv
// Register model of the flash byte array.
// Assumes: MEM_BYTES is a power of two, and SECTOR_BYTES is a power of two no larger than MEM_BYTES.
// Changes take effect only in the commit cycle. Reads are combinational.
module flash_byte_array
    import flash_seq_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 1024,
    parameter int unsigned P0_BYTES     = 512,
    parameter int unsigned SECTOR_BYTES = 128,
    localparam int unsigned IDX_W       = $clog2(MEM_BYTES),
    localparam int unsigned SEC_W       = $clog2(SECTOR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  flash_op_e        op,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [7:0]           mem [MEM_BYTES];
    logic [MEM_BYTES-1:0] erase_hit;
    logic [MEM_BYTES-1:0] prog_hit;

    // Per-byte select lines for erase and program.
    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_sel
        localparam logic [IDX_W-SEC_W-1:0] SEC_OF_I = (IDX_W-SEC_W)'(i / SECTOR_BYTES);
        localparam bit IN_P0 = (i < P0_BYTES);
        assign erase_hit[i] = (op == OP_CHIP) ||
                              ((op == OP_PART) && IN_P0) ||
                              ((op == OP_SECT) && (idx[IDX_W-1:SEC_W] == SEC_OF_I));
        assign prog_hit[i]  = (op == OP_PROG) && (idx == IDX_W'(i));
    end

    // Apply erase (to FFH) or AND-program to the selected bytes at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (erase_hit[i])     mem[i] <= 8'hFF;
                else if (prog_hit[i]) mem[i] <= mem[i] & data;
            end
        end
    end

    // Read port for verify.
    assign rd_byte = mem[rd_idx];

    // A committed program only clears bits of the target byte.
    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_PROG) |=> ((mem[$past(idx)] & ~$past(mem[idx])) == 8'h00));
    // A committed sector erase leaves the addressed byte erased.
    p_sect_erased_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_SECT) |=> (mem[$past(idx)] == 8'hFF));
endmodule

// File: rtl/flash_seq_ctrl.sv
// Command acceptance, busy handshake and verify data path.
// Assumes: strobes last one cycle, and the timer expires exactly once per load.
// Lock and range are checked when a command is accepted.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned PROG_CYC = 4,
    parameter int unsigned SECT_CYC = 4,
    parameter int unsigned PART_CYC = 4,
    parameter int unsigned CHIP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_prog,
    input  logic             cmd_sect,
    input  logic             cmd_part,
    input  logic             cmd_chip,
    input  logic             cmd_verify,
    input  logic             lock,
    input  logic             in_range,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic [7:0]       rd_byte,
    input  logic             expire,
    output logic             ready,
    output logic             done,
    output logic [7:0]       rdata,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             commit,
    output flash_op_e        op_lat,
    output logic [IDX_W-1:0] idx_lat,
    output logic [7:0]       data_lat
);
    flash_op_e req_op;
    logic      allowed;

    // Pick one request by fixed priority.
    always_comb begin
        if (cmd_chip)      req_op = OP_CHIP;
        else if (cmd_part) req_op = OP_PART;
        else if (cmd_sect) req_op = OP_SECT;
        else if (cmd_prog) req_op = OP_PROG;
        else               req_op = OP_NONE;
    end

    // Bulk erases override the lock; targeted operations need lock clear and a valid address.
    always_comb begin
        case (req_op)
            OP_CHIP, OP_PART: allowed = 1'b1;
            OP_SECT, OP_PROG: allowed = !lock && in_range;
            default:          allowed = 1'b0;
        endcase
    end

    // Duration of the requested operation.
    always_comb begin
        case (req_op)
            OP_PROG: load_val = CNT_W'(PROG_CYC);
            OP_SECT: load_val = CNT_W'(SECT_CYC);
            OP_PART: load_val = CNT_W'(PART_CYC);
            default: load_val = CNT_W'(CHIP_CYC);
        endcase
    end

    assign load   = ready && allowed;
    assign commit = !ready && expire;

    // Handshake state: latch the operation on start, release it at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b1;
            done     <= 1'b0;
            op_lat   <= OP_NONE;
            idx_lat  <= '0;
            data_lat <= 8'h00;
        end else begin
            done <= 1'b0;
            if (load) begin
                ready   <= 1'b0;
                op_lat  <= req_op;
                idx_lat <= idx;
                if (req_op == OP_PROG) data_lat <= wdata;
            end else if (commit) begin
                ready  <= 1'b1;
                done   <= 1'b1;
                op_lat <= OP_NONE;
            end
        end
    end

    // Verify data path: polling pattern while busy, masked when locked or out of range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (cmd_verify) begin
            if (!ready)
                rdata <= (op_lat == OP_PROG) ? {4'b0000, ~data_lat[3], 3'b000} : 8'h00;
            else if (lock || !in_range)
                rdata <= 8'h00;
            else
                rdata <= rd_byte;
        end
    end

    // A running operation is not disturbed by new strobes.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !expire) |=> ($stable(op_lat) && $stable(idx_lat) && !ready));
    // A locked lone program never raises busy.
    p_locked_prog_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_prog && !cmd_sect && !cmd_part && !cmd_chip && lock) |=> ready);
    // done is a single-cycle pulse.
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Polling during a program carries at most bit 3.
    p_poll_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && op_lat == OP_PROG && cmd_verify) |=> ((rdata & 8'hF7) == 8'h00));
endmodule

// File: rtl/flash_op_sequencer.sv
// Top of the flash operation sequencer: timer, array and control.
// Assumes: strobes are single-cycle, and every duration parameter is at least 1.
// Default durations come from CLK_KHZ: 100 us, 30 ms, 300 ms and 350 ms.
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 1024,
    parameter int unsigned P0_BYTES     = 512,
    parameter int unsigned SECTOR_BYTES = 128,
    parameter int unsigned CLK_KHZ      = 50000,
    parameter int unsigned PROG_CYC     = CLK_KHZ / 10,
    parameter int unsigned SECT_CYC     = CLK_KHZ * 30,
    parameter int unsigned PART_CYC     = CLK_KHZ * 300,
    parameter int unsigned CHIP_CYC     = CLK_KHZ * 350,
    localparam int unsigned IDX_W       = $clog2(MEM_BYTES),
    localparam int unsigned MAX_A       = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC,
    localparam int unsigned MAX_B       = (PART_CYC > CHIP_CYC) ? PART_CYC : CHIP_CYC,
    localparam int unsigned MAX_CYC     = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_prog,
    input  logic        cmd_sect_erase,
    input  logic        cmd_part_erase,
    input  logic        cmd_chip_erase,
    input  logic        cmd_verify,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        lock_active,
    output logic [7:0]  rdata,
    output logic        ready,
    output logic        done
);
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic [7:0]       rd_byte;
    logic             expire;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             commit;
    flash_op_e        op_lat;
    logic [IDX_W-1:0] idx_lat;
    logic [7:0]       data_lat;

    assign idx = addr[IDX_W-1:0];

    // Range check only exists when the array is smaller than the address space.
    if (IDX_W < 16) begin : g_range
        assign in_range = (addr[15:IDX_W] == '0);
    end else begin : g_full
        assign in_range = 1'b1;
    end

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
    );

    flash_byte_array #(
        .MEM_BYTES(MEM_BYTES), .P0_BYTES(P0_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(op_lat), .idx(idx_lat),
        .data(data_lat), .rd_idx(idx), .rd_byte(rd_byte)
    );

    flash_seq_ctrl #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
        .PART_CYC(PART_CYC), .CHIP_CYC(CHIP_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_sect(cmd_sect_erase),
        .cmd_part(cmd_part_erase), .cmd_chip(cmd_chip_erase), .cmd_verify(cmd_verify),
        .lock(lock_active), .in_range(in_range), .idx(idx), .wdata(wdata),
        .rd_byte(rd_byte), .expire(expire), .ready(ready), .done(done), .rdata(rdata),
        .load(load), .load_val(load_val), .commit(commit), .op_lat(op_lat),
        .idx_lat(idx_lat), .data_lat(data_lat)
    );
endmodule

// File: tb/flash_op_sequencer_test.sv
`timescale 1ns/1ps
module flash_op_sequencer_test;
    localparam int MEMB = 1024;
    localparam int P0B  = 512;
    localparam int PC   = 6;
    localparam int SC   = 9;
    localparam int PAC  = 12;
    localparam int CC   = 15;
    localparam int K_PROG = 0, K_SECT = 1, K_PART = 2, K_CHIP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_prog = 1'b0, cmd_sect_erase = 1'b0, cmd_part_erase = 1'b0;
    logic cmd_chip_erase = 1'b0, cmd_verify = 1'b0, lock_active = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready, done;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [MEMB];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    flash_op_sequencer #(
        .MEM_BYTES(MEMB), .P0_BYTES(P0B), .SECTOR_BYTES(128),
        .PROG_CYC(PC), .SECT_CYC(SC), .PART_CYC(PAC), .CHIP_CYC(CC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_part_erase(cmd_part_erase), .cmd_chip_erase(cmd_chip_erase),
        .cmd_verify(cmd_verify), .addr(addr), .wdata(wdata), .lock_active(lock_active),
        .rdata(rdata), .ready(ready), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: note a verify at the edge, compare against the scoreboard half a cycle later.
    always @(posedge clk) rd_seen <= cmd_verify;
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%0h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [15:0] a);
        if (a >= MEMB || lock_active) return 8'h00;
        return mdl[a];
    endfunction

    // Driver: issue a verify and push its expected result.
    task automatic do_verify(input logic [15:0] a, input logic [7:0] exp, input string tag);
        addr = a; cmd_verify = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        cmd_verify = 1'b0;
    endtask

    task automatic set_strobe(input int kind, input logic v);
        case (kind)
            K_PROG: cmd_prog = v;
            K_SECT: cmd_sect_erase = v;
            K_PART: cmd_part_erase = v;
            default: cmd_chip_erase = v;
        endcase
    endtask

    // Apply an operation to the reference model.
    task automatic model_apply(input int kind, input logic [15:0] a, input logic [7:0] d);
        for (int i = 0; i < MEMB; i++) begin
            case (kind)
                K_PROG: if (i == int'(a)) mdl[i] = mdl[i] & d;
                K_SECT: if ((i / 128) == (int'(a) / 128)) mdl[i] = 8'hFF;
                K_PART: if (i < P0B) mdl[i] = 8'hFF;
                default: mdl[i] = 8'hFF;
            endcase
        end
    endtask

    // Run one operation; exp_n = 0 means it must be refused.
    task automatic run_op(input int kind, input logic [15:0] a, input logic [7:0] d,
                          input int exp_n, input string tag);
        int n;
        addr = a; wdata = d; set_strobe(kind, 1'b1);
        @(negedge clk);
        set_strobe(kind, 1'b0);
        if (exp_n == 0) begin
            for (int k = 0; k < 3; k++) begin
                check({tag, " refused ready"}, ready, 1);
                check({tag, " refused done"}, done, 0);
                @(negedge clk);
            end
        end else begin
            n = 0;
            while (!ready && n < exp_n + 5) begin
                n++;
                @(negedge clk);
            end
            check({tag, " busy cycles"}, n, exp_n);
            check({tag, " done at ready rise"}, done, 1);
            @(negedge clk);
            check({tag, " done single"}, done, 0);
            model_apply(kind, a, d);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < MEMB; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ready", ready, 1);
        check("R1 done", done, 0);
        check("R1 rdata", rdata, 8'h00);
        do_verify(16'h0000, 8'hFF, "R1 erased 000");
        do_verify(16'h03FF, 8'hFF, "R1 erased 3FF");

        // R2/R3/R8: program, then program again to show AND merge
        run_op(K_PROG, 16'h0010, 8'hA5, PC, "R3 prog");
        do_verify(16'h0010, 8'hA5, "R8 read A5");
        run_op(K_PROG, 16'h0010, 8'h0F, PC, "R2 prog and");
        do_verify(16'h0010, 8'h05, "R2 and result");

        // R9/R10: verify and strobes during a program
        addr = 16'h0020; wdata = 8'h37; cmd_prog = 1'b1;
        @(negedge clk);
        cmd_prog = 1'b0;
        n = 1;
        do_verify(16'h0010, 8'h08, "R9 poll other addr");
        n++;
        addr = 16'h0010; wdata = 8'h00; cmd_prog = 1'b1; cmd_sect_erase = 1'b1;
        @(negedge clk);
        cmd_prog = 1'b0; cmd_sect_erase = 1'b0;
        check("R10 still busy", ready, 0);
        n++;
        forever begin
            @(negedge clk);
            if (ready) break;
            n++;
        end
        check("R10 length unchanged", n, PC);
        model_apply(K_PROG, 16'h0020, 8'h37);
        @(negedge clk);
        do_verify(16'h0010, 8'h05, "R10 dropped strobes");
        do_verify(16'h0020, 8'h37, "R2 prog 37");

        // R7/R8: locked program refused, locked read masked
        lock_active = 1'b1;
        run_op(K_PROG, 16'h0030, 8'h00, 0, "R7 locked prog");
        do_verify(16'h0010, 8'h00, "R8 locked read");
        lock_active = 1'b0;
        do_verify(16'h0030, 8'hFF, "R7 array unchanged");

        // R11: out-of-range address
        run_op(K_PROG, 16'h8010, 8'h00, 0, "R11 prog out of range");
        run_op(K_SECT, 16'h8080, 8'h00, 0, "R11 sect out of range");
        do_verify(16'h8010, 8'h00, "R11 read out of range");
        do_verify(16'h0010, 8'h05, "R11 alias untouched");

        // R4: sector erase boundaries
        run_op(K_PROG, 16'h007F, 8'h00, PC, "R4 setup 07F");
        run_op(K_PROG, 16'h0080, 8'h00, PC, "R4 setup 080");
        run_op(K_PROG, 16'h00FF, 8'h00, PC, "R4 setup 0FF");
        run_op(K_PROG, 16'h0100, 8'h00, PC, "R4 setup 100");
        lock_active = 1'b1;
        run_op(K_SECT, 16'h0090, 8'h00, 0, "R4 locked sect");
        lock_active = 1'b0;
        do_verify(16'h0080, 8'h00, "R4 locked no change");
        addr = 16'h00C5; cmd_sect_erase = 1'b1;
        @(negedge clk);
        cmd_sect_erase = 1'b0;
        n = 1;
        do_verify(16'h0010, 8'h00, "R9 read during erase");
        n++;
        forever begin
            @(negedge clk);
            if (ready) break;
            n++;
        end
        check("R3 sect busy cycles", n, SC);
        model_apply(K_SECT, 16'h00C5, 8'h00);
        @(negedge clk);
        do_verify(16'h0080, model_read(16'h0080), "R4 first byte");
        do_verify(16'h00FF, model_read(16'h00FF), "R4 last byte");
        do_verify(16'h007F, model_read(16'h007F), "R4 below sector");
        do_verify(16'h0100, model_read(16'h0100), "R4 above sector");

        // R5: partition erase overrides lock
        run_op(K_PROG, 16'h0300, 8'h11, PC, "R5 setup 300");
        run_op(K_PROG, 16'h0200, 8'h22, PC, "R5 setup 200");
        run_op(K_PROG, 16'h01FF, 8'h33, PC, "R5 setup 1FF");
        lock_active = 1'b1;
        run_op(K_PART, 16'h0000, 8'h00, PAC, "R5 part locked");
        lock_active = 1'b0;
        do_verify(16'h0010, 8'hFF, "R5 p0 byte 010");
        do_verify(16'h01FF, 8'hFF, "R5 p0 last byte");
        do_verify(16'h0200, 8'h22, "R5 p1 first byte");
        do_verify(16'h0300, 8'h11, "R5 p1 byte 300");

        // R6: whole-array erase overrides lock
        lock_active = 1'b1;
        run_op(K_CHIP, 16'h0000, 8'h00, CC, "R6 chip locked");
        lock_active = 1'b0;
        do_verify(16'h0300, 8'hFF, "R6 byte 300");
        do_verify(16'h0200, 8'hFF, "R6 byte 200");
        @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule